// File: doc/BRIEF.md
# Single-Pass Background Scan Engine for SRAM Test

This engine drives one single-port SRAM of 2**ADDR_W words through exactly one ascending address pass per run. A run either writes a data background into every word or reads every word back and compares it against the same background. Because writing and checking are separate runs, an outside test controller can hold the memory untouched between them. That gap serves for a data-retention pause or a quiescent supply-current measurement.

Four backgrounds are available: solid, checkerboard, column bar and row bar. A polarity input inverts any of them. The engine assumes a synchronous-read memory, so it checks returned data one cycle after it issues each read. Any mismatch sets a sticky fail flag. A one-cycle done pulse marks the point at which the pass and all of its compares are complete.

Top module: `bgscan_engine`

## Requirements
- R1: While reset (active low) is held, and in the first cycle after it, mem_we, mem_re, done and fail are 0 and mem_addr is 0.
- R2: A start accepted at a clock edge begins a pass in the following cycle. The pass presents address 0, then addresses that rise by one each cycle up to 2**ADDR_W-1, giving exactly 2**ADDR_W consecutive operations.
- R3: The 3-bit pat_sel is decoded as follows. Bit 2 selects the operation: 1 for a read scan, 0 for a write scan. Bits 1:0 select the background: 00 solid, 01 checkerboard, 10 column bar, 11 row bar. pat_sel and pol are captured when start is accepted, and later changes have no effect on a pass already running.
- R4: In a write scan, mem_we is 1 and mem_re is 0 on every operation, and mem_wdata equals the background word for the current address.
- R5: Let row = address bit COL_W and col = address bit 0, and let b be the bit index within the word. The backgrounds set bit b as follows, and pol=1 inverts every bit:
  - solid: 0
  - checkerboard: b[0] XOR row XOR col
  - column bar: b[0]
  - row bar: row
- R6: In a read scan, mem_re is 1 and mem_we is 0 on every operation. mem_rdata is compared in the cycle after the read, and a mismatch becomes visible on fail one cycle after that.
- R7: fail is cleared by an accepted start, never set during a write scan, set by any read mismatch, and held until the next accepted start.
- R8: done is high for exactly one cycle, two cycles after the last operation of a pass. At that point fail already reflects every compare of the pass.
- R9: A start raised while a pass runs, or in the cycle after its last operation, is ignored.
- R10: Outside a pass, mem_we and mem_re stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a pass |
| pat_sel | input | 3 | Operation and background selection |
| pol | input | 1 | Background inversion |
| mem_rdata | input | DATA_W | Read data from the memory, one cycle after mem_re |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| done | output | 1 | One-cycle end-of-pass pulse |
| fail | output | 1 | Sticky compare failure |

## Verification
The bench builds the engine with ADDR_W=4, COL_W=2 and DATA_W=8, which gives 16 words arranged as four rows of four. With these values the row and column alternation of each background shows up within a single pass. A corrupted word can be placed at the first, a middle and the last address. This puts the exact cycle at which fail rises in reach, including the case where the last compare lands on the done cycle. Mismatched write and read backgrounds and polarities then exercise fail with no injected fault.

// File: rtl/bgscan_pkg.sv
package bgscan_pkg;

  typedef enum logic [1:0] {
    BG_SOLID   = 2'b00,
    BG_CHECKER = 2'b01,
    BG_COLBAR  = 2'b10,
    BG_ROWBAR  = 2'b11
  } bg_kind_e;

  typedef struct packed {
    logic     rd;
    bg_kind_e kind;
    logic     inv;
  } scan_mode_t;

endpackage

// File: rtl/bgscan_seq.sv
module bgscan_seq
  import bgscan_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        pat_sel,
  input  logic              pol,
  input  logic              pend,
  output logic              run,
  output logic [ADDR_W-1:0] addr,
  output logic              issue_last,
  output logic              start_acc,
  output scan_mode_t        mode_q
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  assign start_acc  = start && !run && !pend;
  assign issue_last = run && (addr == LAST_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      addr   <= '0;
      mode_q <= '0;
    end else if (start_acc) begin
      run         <= 1'b1;
      addr        <= '0;
      mode_q.rd   <= pat_sel[2];
      mode_q.kind <= bg_kind_e'(pat_sel[1:0]);
      mode_q.inv  <= pol;
    end else if (run) begin
      if (issue_last) run <= 1'b0;
      else            addr <= addr + 1'b1;
    end
  end

endmodule

// File: rtl/bgscan_bg.sv
module bgscan_bg
  import bgscan_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  bg_kind_e          kind,
  input  logic              inv,
  input  logic              row_lsb,
  input  logic              col_lsb,
  output logic [DATA_W-1:0] word
);

  function automatic logic [DATA_W-1:0] bg_word(bg_kind_e k, logic iv,
                                                logic r, logic c);
    logic [DATA_W-1:0] w;
    for (int b = 0; b < DATA_W; b++) begin
      logic odd;
      odd = (b % 2) != 0;
      unique case (k)
        BG_SOLID:   w[b] = 1'b0;
        BG_CHECKER: w[b] = odd ^ r ^ c;
        BG_COLBAR:  w[b] = odd;
        default:    w[b] = r;
      endcase
      w[b] = w[b] ^ iv;
    end
    return w;
  endfunction

  assign word = bg_word(kind, inv, row_lsb, col_lsb);

endmodule

// File: rtl/bgscan_cmp.sv
module bgscan_cmp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_acc,
  input  logic              op_v,
  input  logic              op_rd,
  input  logic              op_last,
  input  logic [DATA_W-1:0] exp_word,
  input  logic [DATA_W-1:0] rdata,
  output logic              pend,
  output logic              mismatch,
  output logic              fail,
  output logic              done
);

  logic              v_q, rd_q, last_q;
  logic [DATA_W-1:0] exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      rd_q   <= 1'b0;
      last_q <= 1'b0;
      exp_q  <= '0;
    end else begin
      v_q    <= op_v;
      rd_q   <= op_v && op_rd;
      last_q <= op_last;
      exp_q  <= exp_word;
    end
  end

  assign pend     = v_q;
  assign mismatch = rd_q && (rdata != exp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= v_q && last_q;
      if (start_acc)     fail <= 1'b0;
      else if (mismatch) fail <= 1'b1;
    end
  end

endmodule

// File: rtl/bgscan_engine.sv
module bgscan_engine
  import bgscan_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int COL_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        pat_sel,
  input  logic              pol,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic              done,
  output logic              fail
);

  scan_mode_t        mode_q;
  logic              run, issue_last, start_acc, pend, mismatch, busy, scan_rd;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] bg_w;

  bgscan_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_sel(pat_sel), .pol(pol),
    .pend(pend), .run(run), .addr(addr), .issue_last(issue_last),
    .start_acc(start_acc), .mode_q(mode_q)
  );

  bgscan_bg #(.DATA_W(DATA_W)) u_bg (
    .kind(mode_q.kind), .inv(mode_q.inv),
    .row_lsb(addr[COL_W]), .col_lsb(addr[0]), .word(bg_w)
  );

  bgscan_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .op_v(run),
    .op_rd(mode_q.rd), .op_last(issue_last), .exp_word(bg_w),
    .rdata(mem_rdata), .pend(pend), .mismatch(mismatch),
    .fail(fail), .done(done)
  );

  assign scan_rd   = mode_q.rd;
  assign busy      = run || pend;
  assign mem_addr  = addr;
  assign mem_wdata = bg_w;
  assign mem_we    = run && !scan_rd;
  assign mem_re    = run && scan_rd;

endmodule

// File: rtl/bgscan_chk.sv
module bgscan_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              busy,
  input logic              start_acc,
  input logic              issue_last,
  input logic              scan_rd,
  input logic              mismatch,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic              done,
  input logic              fail
);

  // R4
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R2
  start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (run && mem_addr == '0));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !issue_last) |=> (run && mem_addr == $past(mem_addr) + 1'b1));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  fail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> !fail);

  // R7
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fail || mismatch) && !start_acc) |=> fail);

  // R7
  write_no_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !scan_rd) |-> !fail);

  // R9
  run_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(!busy));

endmodule

bind bgscan_engine bgscan_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .busy(busy), .start_acc(start_acc),
  .issue_last(issue_last), .scan_rd(scan_rd), .mismatch(mismatch),
  .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
  .done(done), .fail(fail)
);

// File: tb/tb_bgscan_engine.sv
module tb_bgscan_engine;
  localparam int ADDR_W = 4;
  localparam int COL_W  = 2;
  localparam int DATA_W = 8;
  localparam int N      = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pol = 1'b0;
  logic [2:0]        pat_sel = '0;
  logic [DATA_W-1:0] mem_rdata;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic mem_we, mem_re, done, fail;
  logic cor_req = 1'b0;
  logic [ADDR_W-1:0] cor_addr = '0;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  bgscan_engine #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_sel(pat_sel), .pol(pol),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .done(done), .fail(fail)
  );

  logic [DATA_W-1:0] mem [N];
  always @(posedge clk) begin
    if (cor_req) mem[cor_addr][0] <= ~mem[cor_addr][0];
    if (mem_we)  mem[mem_addr] <= mem_wdata;
    if (mem_re)  mem_rdata <= mem[mem_addr];
  end

  typedef struct packed {
    logic [1:0] wk; logic wp; logic [1:0] rk; logic rp; logic ce; logic [3:0] ca;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd0},
    '{2'd1, 1'b0, 2'd1, 1'b0, 1'b1, 4'd5},
    '{2'd2, 1'b1, 2'd2, 1'b1, 1'b0, 4'd0},
    '{2'd3, 1'b0, 2'd3, 1'b0, 1'b1, 4'd15},
    '{2'd0, 1'b0, 2'd0, 1'b1, 1'b0, 4'd0},
    '{2'd1, 1'b1, 2'd1, 1'b1, 1'b1, 4'd0},
    '{2'd2, 1'b0, 2'd1, 1'b0, 1'b0, 4'd0},
    '{2'd3, 1'b1, 2'd3, 1'b1, 1'b0, 4'd0}
  };

  function automatic logic [DATA_W-1:0] model_bg(int kind, int p, int a);
    logic [DATA_W-1:0] w;
    int row, col, v;
    row = (a / (1 << COL_W)) % 2;
    col = a % 2;
    for (int b = 0; b < DATA_W; b++) begin
      case (kind)
        0:       v = 0;
        1:       v = (b + row + col) % 2;
        2:       v = b % 2;
        default: v = row;
      endcase
      w[b] = ((v + p) % 2) == 1;
    end
    return w;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Runs one pass from a negedge. poke >= 0 raises start in that cycle of the pass.
  task automatic run_pass(input bit rd, input int kind, input bit p,
                          input int poke, input int first_bad);
    pat_sel = {rd, 2'(kind)};
    pol     = p;
    start   = 1'b1;
    @(posedge clk); @(negedge clk);
    for (int k = 0; k <= N + 1; k++) begin
      start = (k == poke);
      if (k == 0) begin
        pat_sel = ~{rd, 2'(kind)};  // R3: later select changes must not matter
        pol     = ~p;
      end
      if (k < N) begin
        check("R2", "addr", int'(mem_addr), k);
        check(rd ? "R6" : "R4", "we", int'(mem_we), int'(!rd));
        check(rd ? "R6" : "R4", "re", int'(mem_re), int'(rd));
        if (!rd) check("R5", "wdata", int'(mem_wdata), int'(model_bg(kind, p, k)));
        check("R8", "done early", int'(done), 0);
      end else begin
        check("R10", "we after pass", int'(mem_we), 0);
        check("R10", "re after pass", int'(mem_re), 0);
        check("R8", "done", int'(done), int'(k == N + 1));
      end
      check("R7", "fail", int'(fail), int'(first_bad >= 0 && k >= first_bad + 2));
      @(posedge clk); @(negedge clk);
    end
    start = 1'b0;
    check("R9", "no restart we", int'(mem_we), 0);
    check("R9", "no restart re", int'(mem_re), 0);
    check("R8", "done single", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int fb;
    repeat (3) @(negedge clk);
    check("R1", "we in reset", int'(mem_we), 0);
    check("R1", "re in reset", int'(mem_re), 0);
    check("R1", "done in reset", int'(done), 0);
    check("R1", "fail in reset", int'(fail), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "addr after reset", int'(mem_addr), 0);
    check("R1", "we after reset", int'(mem_we), 0);

    foreach (VECS[i]) begin
      run_pass(1'b0, int'(VECS[i].wk), VECS[i].wp, -1, -1);
      if (VECS[i].ce) begin
        cor_addr = VECS[i].ca;
        cor_req  = 1'b1;
        @(negedge clk);
        cor_req  = 1'b0;
      end
      repeat (2) @(negedge clk);  // retention gap
      fb = -1;
      for (int a = N - 1; a >= 0; a--)
        if (mem[a] != model_bg(int'(VECS[i].rk), int'(VECS[i].rp), a)) fb = a;
      run_pass(1'b1, int'(VECS[i].rk), VECS[i].rp, -1, fb);
      repeat (3) @(negedge clk);
      check("R7", "fail held", int'(fail), int'(fb >= 0));
    end

    // R9: start during a running write pass and in the cycle after its end
    run_pass(1'b0, 1, 1'b0, 3, -1);
    run_pass(1'b1, 1, 1'b0, N, -1);
    // R7: fail from a bad read clears on the next start
    run_pass(1'b1, 0, 1'b1, -1, 0);
    run_pass(1'b0, 3, 1'b0, -1, -1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule